// File: doc/BRIEF.md
# Register-Mapped GPIO Bank with Pin Interrupts

This block manages a group of general-purpose pins arranged as four ports of eight pins each. Software reaches it over a single-cycle register bus (byte address, write data, write enable, combinational read data). For every pin it holds a mode select that hands the pad either to the bank's own registers or to an alternate-function source. It also holds an output-enable bit and an output value, and it returns a synchronized copy of the pin level.

Every pin can raise an interrupt on a rising edge, a falling edge, both edges, a high level or a low level. Each port has latched status bits, enable bits and a write-one-to-clear register. One combined interrupt line leaves the bank. A second address window, offset by 0x800, performs masked writes: one bus write changes only the pins selected in its mask byte. Several agents can therefore each control their own pins without a read-modify-write sequence.

Top module: `gpio_bank`

## Requirements
- R1: After reset all configuration, output, enable, type and status registers are 0, `irq` is low, and, because every mode bit is 0, `pin_out`/`pin_oe` equal `alt_out`/`alt_oe`.
- R2: Byte address = group offset + 4 × port (port 0..3), with group offsets mode 0x00, output enable 0x10, output 0x20, input 0x30, status 0x40, enable 0x50, type 0x60, clear 0x70. Reads of the clear group, of the masked window (address bit 11 set) and of any other address return 0.
- R3: A plain write stores `wdata[7:0]` into mode, output-enable, output or enable registers and `wdata[23:0]` into the type register. Plain writes to the input and status groups are ignored.
- R4: A write at the plain address + 0x800 updates only pins whose bit in `wdata[15:8]` is 1, giving them the value in `wdata[7:0]`. This applies to mode, output enable, output, enable and status; for the type register only its low (polarity) byte is updated this way.
- R5: For each pin, a mode bit of 1 drives `pin_out`/`pin_oe` from the output and output-enable registers; a mode bit of 0 drives them from `alt_out`/`alt_oe`.
- R6: `pin_in` passes through two flops; a change applied before a clock edge reads back from the input group after the second edge, in bits 7:0 of the port's word.
- R7: Type word bit n is polarity (1 = high/rising), bit n+8 selects edge, bit n+16 selects both edges. Rising = 0x000101, falling = 0x000100, both = 0x010100 (each shifted by n). An edge sets the status bit on the clock after the synchronized level changes, and it stays set.
- R8: Level high = 0x000001, level low = 0x000000 (shifted by n). A level pin's status stays set, and is set again in the same cycle as a clear, while its level condition holds.
- R9: Writing 1 to a bit of the clear group clears that pin's status; writing 0 leaves it unchanged. An edge status remains set until cleared.
- R10: `irq` is high exactly when some status bit and its enable bit are both 1 in any port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we | input | 1 | Write strobe for the current address |
| addr | input | AW (12) | Byte address of the register |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| pin_in | input | NPORT×8 | Raw pin levels, pin 8p+b is port p bit b |
| alt_out | input | NPORT×8 | Alternate-function output values |
| alt_oe | input | NPORT×8 | Alternate-function output enables |
| pin_out | output | NPORT×8 | Value presented to each pad |
| pin_oe | output | NPORT×8 | Output enable presented to each pad |
| irq | output | 1 | Combined interrupt of all ports |

## Verification
The bench targets the masked window with a zero mask and with a partial mask. A design that ignored the mask would overwrite pins it must leave alone. One that merged the wrong byte would garble the stored value. The type register is checked one pin at a time for all five trigger kinds. Swapped polarity or a missing both-edges override would latch status on the wrong transition. Clearing is checked against a still-asserted level and against a zero clear word: a design that let the clear win over the level, or cleared on 0 bits, would return the wrong status. The two-flop input latency and the OR across ports of the interrupt line are also sampled at the exact cycles where an off-by-one or a single-port OR would show.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Pins per port, fixed by the 8-bit value / 8-bit mask write format
    localparam int PINS = 8;

    typedef enum logic [2:0] {
        GRP_MODE = 3'd0,
        GRP_OE   = 3'd1,
        GRP_OUT  = 3'd2,
        GRP_IN   = 3'd3,
        GRP_STA  = 3'd4,
        GRP_IE   = 3'd5,
        GRP_TYPE = 3'd6,
        GRP_CLR  = 3'd7
    } grp_e;

    // Packed so that the word layout is {both, edge select, polarity}
    typedef struct packed {
        logic [PINS-1:0] both;
        logic [PINS-1:0] edge_sel;
        logic [PINS-1:0] pol;
    } trig_t;

    typedef struct packed {
        logic [PINS-1:0] mode;
        logic [PINS-1:0] oe;
        logic [PINS-1:0] out;
        logic [PINS-1:0] ie;
        logic [PINS-1:0] status;
        logic [PINS-1:0] prev;
        trig_t           trig;
    } port_regs_t;

    function automatic logic [PINS-1:0] masked_merge(
        input logic [PINS-1:0] old_val,
        input logic [2*PINS-1:0] mw
    );
        return (old_val & ~mw[2*PINS-1:PINS]) | (mw[PINS-1:0] & mw[2*PINS-1:PINS]);
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
    parameter int W = 8
) (
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] edge_sel,
    input  logic [W-1:0] both,
    output logic [W-1:0] hit
);
    logic [W-1:0] rise, fall, edge_hit, lvl_hit;

    always_comb begin
        rise     = lvl & ~prev;
        fall     = ~lvl & prev;
        // both-edges overrides polarity
        edge_hit = (both & (rise | fall))
                 | (~both & pol & rise)
                 | (~both & ~pol & fall);
        lvl_hit  = (pol & lvl) | (~pol & ~lvl);
        hit      = (edge_sel & edge_hit) | (~edge_sel & lvl_hit);
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_bank_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_wr,
    input  logic            alias_wr,
    input  grp_e            grp,
    input  logic [23:0]     wdata,
    input  logic [PINS-1:0] lvl,
    input  logic [PINS-1:0] alt_out,
    input  logic [PINS-1:0] alt_oe,
    output port_regs_t      regs,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_oe,
    output logic            pend
);
    port_regs_t      regs_d, regs_q;
    logic [PINS-1:0] hit_d;
    logic [PINS-1:0] clr_d;

    gpio_trig_detect #(.W(PINS)) u_detect (
        .lvl      (lvl),
        .prev     (regs_q.prev),
        .pol      (regs_q.trig.pol),
        .edge_sel (regs_q.trig.edge_sel),
        .both     (regs_q.trig.both),
        .hit      (hit_d)
    );

    always_comb begin
        regs_d      = regs_q;
        clr_d       = '0;
        regs_d.prev = lvl;
        if (sel_wr && !alias_wr) begin
            case (grp)
                GRP_MODE: regs_d.mode = wdata[PINS-1:0];
                GRP_OE:   regs_d.oe   = wdata[PINS-1:0];
                GRP_OUT:  regs_d.out  = wdata[PINS-1:0];
                GRP_IE:   regs_d.ie   = wdata[PINS-1:0];
                GRP_TYPE: regs_d.trig = trig_t'(wdata);
                GRP_CLR:  clr_d       = wdata[PINS-1:0];
                default:  ;
            endcase
        end else if (sel_wr) begin
            case (grp)
                GRP_MODE: regs_d.mode     = masked_merge(regs_q.mode, wdata[15:0]);
                GRP_OE:   regs_d.oe       = masked_merge(regs_q.oe, wdata[15:0]);
                GRP_OUT:  regs_d.out      = masked_merge(regs_q.out, wdata[15:0]);
                GRP_IE:   regs_d.ie       = masked_merge(regs_q.ie, wdata[15:0]);
                GRP_TYPE: regs_d.trig.pol = masked_merge(regs_q.trig.pol, wdata[15:0]);
                GRP_STA:  regs_d.status   = masked_merge(regs_q.status, wdata[15:0]);
                default:  ;
            endcase
        end
        // a detection in the same cycle wins over a clear
        regs_d.status = (regs_d.status & ~clr_d) | hit_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs    = regs_q;
    assign pad_out = (regs_q.mode & regs_q.out) | (~regs_q.mode & alt_out);
    assign pad_oe  = (regs_q.mode & regs_q.oe)  | (~regs_q.mode & alt_oe);
    assign pend    = |(regs_q.status & regs_q.ie);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPORT = 4,   // at most 4: four 4-byte slots per 16-byte group
    parameter int AW    = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [AW-1:0]         addr,
    input  logic [31:0]           wdata,
    output logic [31:0]           rd_data,
    input  logic [NPORT*PINS-1:0] pin_in,
    input  logic [NPORT*PINS-1:0] alt_out,
    input  logic [NPORT*PINS-1:0] alt_oe,
    output logic [NPORT*PINS-1:0] pin_out,
    output logic [NPORT*PINS-1:0] pin_oe,
    output logic                  irq
);
    localparam int NPIN = NPORT * PINS;
    localparam int PW   = 2;

    logic [NPIN-1:0]  lvl_sync;
    logic             in_map, alias_hit;
    grp_e             grp;
    logic [PW-1:0]    port_idx;
    logic [NPORT-1:0] pend;
    port_regs_t       regs [NPORT];
    logic [NPIN-1:0]  out_all, cfg_all, ie_all, status_all;
    port_regs_t       sel_regs;
    logic [PINS-1:0]  sel_lvl;
    logic             unused_hi;

    assign unused_hi = ^wdata[31:24];
    assign alias_hit = addr[11];
    assign grp       = grp_e'(addr[6:4]);
    assign port_idx  = addr[3:2];
    assign in_map    = ((addr >> 12) == '0) && (addr[10:7] == 4'd0)
                    && (addr[1:0] == 2'd0) && (int'(port_idx) < NPORT);

    gpio_sync2 #(.W(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (lvl_sync)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        gpio_port u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel_wr   (we && in_map && (port_idx == PW'(p))),
            .alias_wr (alias_hit),
            .grp      (grp),
            .wdata    (wdata[23:0]),
            .lvl      (lvl_sync[p*PINS +: PINS]),
            .alt_out  (alt_out[p*PINS +: PINS]),
            .alt_oe   (alt_oe[p*PINS +: PINS]),
            .regs     (regs[p]),
            .pad_out  (pin_out[p*PINS +: PINS]),
            .pad_oe   (pin_oe[p*PINS +: PINS]),
            .pend     (pend[p])
        );
        assign out_all[p*PINS +: PINS]    = regs[p].out;
        assign cfg_all[p*PINS +: PINS]    = regs[p].mode;
        assign ie_all[p*PINS +: PINS]     = regs[p].ie;
        assign status_all[p*PINS +: PINS] = regs[p].status;
    end

    always_comb begin
        sel_regs = '0;
        sel_lvl  = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (port_idx == PW'(p)) begin
                sel_regs = regs[p];
                sel_lvl  = lvl_sync[p*PINS +: PINS];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (in_map && !alias_hit) begin
            case (grp)
                GRP_MODE: rd_data[PINS-1:0] = sel_regs.mode;
                GRP_OE:   rd_data[PINS-1:0] = sel_regs.oe;
                GRP_OUT:  rd_data[PINS-1:0] = sel_regs.out;
                GRP_IN:   rd_data[PINS-1:0] = sel_lvl;
                GRP_STA:  rd_data[PINS-1:0] = sel_regs.status;
                GRP_IE:   rd_data[PINS-1:0] = sel_regs.ie;
                GRP_TYPE: rd_data[3*PINS-1:0] = sel_regs.trig;
                default:  rd_data = '0;
            endcase
        end
    end

    assign irq = |pend;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPIN = 32,
    parameter int AW   = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            we,
    input logic [AW-1:0]   addr,
    input logic [31:0]     wdata,
    input logic [31:0]     rd_data,
    input logic            irq,
    input logic [NPIN-1:0] pin_out,
    input logic [NPIN-1:0] out_all,
    input logic [NPIN-1:0] cfg_all,
    input logic [NPIN-1:0] ie_all,
    input logic [NPIN-1:0] status_all
);
    logic clr_wr, sta_alias_wr, out0_zero_mask_wr, clr_read;

    assign clr_wr            = we && (addr[6:4] == GRP_CLR);
    assign sta_alias_wr      = we && addr[11] && (addr[6:4] == GRP_STA);
    assign out0_zero_mask_wr = we && (addr == AW'(12'h820)) && (wdata[15:8] == 8'h00);
    assign clr_read          = !addr[11] && (addr[6:4] == GRP_CLR);

    // R1
    enables_clear_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ie_all == '0));

    // R10
    no_irq_without_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_all == '0) |-> !irq);

    // R4
    zero_mask_keeps_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out0_zero_mask_wr |=> $stable(out_all[7:0]));

    // R9
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_wr && !sta_alias_wr) |=> (($past(status_all) & ~status_all) == '0));

    // R2
    clear_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_read |-> (rd_data == 32'h0));

    // R5
    gpio_mode_pads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_all == '1) |-> (pin_out == out_all));
endmodule

bind gpio_bank gpio_bank_chk #(.NPIN(NPORT * gpio_bank_pkg::PINS), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (we),
    .addr       (addr),
    .wdata      (wdata),
    .rd_data    (rd_data),
    .irq        (irq),
    .pin_out    (pin_out),
    .out_all    (out_all),
    .cfg_all    (cfg_all),
    .ie_all     (ie_all),
    .status_all (status_all)
);

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
module tb_gpio_bank;
    localparam int NPORT = 4;
    localparam int AW    = 12;
    localparam int NPIN  = NPORT * 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            we = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rd_data;
    logic [NPIN-1:0] pin_in = '0;
    logic [NPIN-1:0] alt_out = 32'hDEADBEEF;
    logic [NPIN-1:0] alt_oe = 32'h0F0F0F0F;
    logic [NPIN-1:0] pin_out, pin_oe;
    logic            irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;   // 125 MHz

    gpio_bank #(.NPORT(NPORT), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .pin_in(pin_in), .alt_out(alt_out), .alt_oe(alt_oe),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] a;
        logic [31:0] d;     // write data, or expected read data
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h000, 32'h0,        4'd1},  // R1 mode p0 after reset
        '{1'b0, 12'h058, 32'h0,        4'd1},  // R1 enable p2 after reset
        '{1'b0, 12'h044, 32'hFF,       4'd8},  // R8 level-low default latches
        '{1'b1, 12'h004, 32'hFFFFFFA5, 4'd3},  // R3 plain mode p1
        '{1'b0, 12'h004, 32'hA5,       4'd3},
        '{1'b1, 12'h020, 32'h3C,       4'd3},  // R3 plain out p0
        '{1'b0, 12'h020, 32'h3C,       4'd3},
        '{1'b1, 12'h820, 32'hF0A0,     4'd4},  // R4 partial mask
        '{1'b0, 12'h020, 32'hAC,       4'd4},
        '{1'b1, 12'h820, 32'h00FF,     4'd4},  // R4 zero mask
        '{1'b0, 12'h020, 32'hAC,       4'd4},
        '{1'b1, 12'h06C, 32'hFF123456, 4'd3},  // R3 type p3, 24 bits kept
        '{1'b0, 12'h06C, 32'h123456,   4'd3},
        '{1'b1, 12'h86C, 32'h0F0F,     4'd4},  // R4 masked type: polarity byte only
        '{1'b0, 12'h06C, 32'h12345F,   4'd4},
        '{1'b1, 12'h030, 32'hFF,       4'd3},  // R3 input write ignored
        '{1'b0, 12'h030, 32'h0,        4'd3},
        '{1'b1, 12'h040, 32'h0,        4'd3},  // R3 plain status write ignored
        '{1'b0, 12'h040, 32'hFF,       4'd3},
        '{1'b0, 12'h070, 32'h0,        4'd2},  // R2 clear reads 0
        '{1'b0, 12'h080, 32'h0,        4'd2},  // R2 unmapped
        '{1'b0, 12'h820, 32'h0,        4'd2},  // R2 masked window reads 0
        '{1'b1, 12'h018, 32'h77,       4'd2},  // R2 oe p2 at 0x10 + 8
        '{1'b0, 12'h018, 32'h77,       4'd2},
        '{1'b0, 12'h014, 32'h0,        4'd2},
        '{1'b0, 12'h010, 32'h0,        4'd2}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a,
                          input logic [31:0] msk, input logic [31:0] exp);
        addr = a;
        #1;
        chk(tag, rd_data & msk, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state at the pads and interrupt
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 pin_out", pin_out, alt_out);
        chk("R1 pin_oe", pin_oe, alt_oe);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) wr(VECS[i].a, VECS[i].d);
            else begin
                addr = VECS[i].a;
                #1;
                chk($sformatf("R%0d vector %0d", VECS[i].req, i), rd_data, VECS[i].d);
            end
        end

        // R5 pad mux on port 1 (mode 0xA5)
        wr(12'h024, 32'hFF);
        wr(12'h014, 32'h0F);
        #1;
        chk("R5 pad out p1", {24'd0, pin_out[15:8]},
            {24'd0, (8'hA5 & 8'hFF) | (~8'hA5 & alt_out[15:8])});
        chk("R5 pad oe p1", {24'd0, pin_oe[15:8]},
            {24'd0, (8'hA5 & 8'h0F) | (~8'hA5 & alt_oe[15:8])});

        // R6 two-flop input latency
        @(negedge clk);
        pin_in[7:0] = 8'h81;
        @(negedge clk);
        rd_chk("R6 input after one edge", 12'h030, 32'hFF, 32'h00);
        @(negedge clk);
        rd_chk("R6 input after two edges", 12'h030, 32'hFF, 32'h81);

        // R7 type setup: pin0 rising, pin1 falling, pin2 both, pin3 level high
        pin_in[7:0] = 8'h00;
        idle(4);
        wr(12'h060, (32'h000101 << 0) | (32'h000100 << 1) | (32'h010100 << 2) | (32'h000001 << 3));
        wr(12'h070, 32'hFF);
        rd_chk("R7 quiet after clear", 12'h040, 32'h0F, 32'h0);
        pin_in[3:0] = 4'hF;
        idle(4);
        rd_chk("R7 rising edges", 12'h040, 32'h0F, 32'hD);

        // R9 clear one bit, then a zero clear
        wr(12'h070, 32'h01);
        rd_chk("R9 clear pin0", 12'h040, 32'h0F, 32'hC);
        wr(12'h070, 32'h00);
        rd_chk("R9 zero clear", 12'h040, 32'h0F, 32'hC);
        // R8 level high survives its clear
        wr(12'h070, 32'h0F);
        rd_chk("R8 level high re-set", 12'h040, 32'h0F, 32'h8);

        pin_in[3:0] = 4'h0;
        idle(4);
        rd_chk("R7 falling edges", 12'h040, 32'h0F, 32'hE);
        wr(12'h070, 32'h0F);
        rd_chk("R9 all cleared", 12'h040, 32'h0F, 32'h0);
        wr(12'h070, 32'hF0);
        rd_chk("R8 level low re-set", 12'h040, 32'hF0, 32'hF0);

        // R4 masked status set and clear
        wr(12'h840, 32'h0202);
        rd_chk("R4 status set by mask", 12'h040, 32'h02, 32'h02);
        wr(12'h840, 32'h0200);
        rd_chk("R4 status cleared by mask", 12'h040, 32'h02, 32'h00);

        // R10 combined interrupt
        chk("R10 no enables", {31'd0, irq}, 32'd0);
        wr(12'h058, 32'h10);
        #1;
        chk("R10 port2 pending", {31'd0, irq}, 32'd1);
        wr(12'h858, 32'h1000);
        #1;
        chk("R10 port2 masked off", {31'd0, irq}, 32'd0);
        wr(12'h05C, 32'h80);
        #1;
        chk("R10 port3 pending", {31'd0, irq}, 32'd1);
        wr(12'h05C, 32'h00);
        #1;
        chk("R10 all disabled", {31'd0, irq}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule